// File: doc/BRIEF.md
# Serial ADC Single-Conversion Sequencer

This block is an SPI master that performs one conversion on an external 12-bit multichannel analog-to-digital converter. A one-cycle start request carries a 3-bit input channel, a range-select bit and a bipolar-mode bit. The sequencer pulls chip select low and shifts out an 8-bit control word. It then leaves the serial clock idle for a fixed conversion time and reads back a 12-bit code. After that it releases chip select and presents the code with a one-cycle done pulse.

Chip select stays low across the whole sequence, from the control write through the idle wait to the read frame. The serial clock half-period and the wait length are parameters counted in system clock cycles. With the defaults and a 50 MHz system clock, each clock phase lasts 200 ns and the wait lasts 15 µs. A second output extends the code to a wider word. In bipolar mode it sign-extends the code, since the converter then returns two's complement. In unipolar mode it zero-extends the code.

Top module: `adc_conv_seq`

## Requirements
- R1: The control word is sent MSB first. It has bit 7 set to 1, the channel in bits 6:4, the range bit in bit 3, the bipolar bit in bit 2, and zeros in bits 1:0.
- R2: The link uses SPI mode 0. The serial clock idles low. MOSI changes only at falling edges or while the clock is low. MISO is sampled at rising edges.
- R3: Every high phase and every low phase of the serial clock lasts HALF_DIV system cycles, which is 10 by default (200 ns at 50 MHz). The first rising edge comes HALF_DIV cycles after the start is accepted.
- R4: After the eighth falling edge, chip select stays low and the serial clock stays low for WAIT_CYC cycles (750 by default). The read frame starts after that wait.
- R5: The read frame has exactly 12 rising edges, and the code is assembled MSB first. Chip select rises in the same cycle that done is asserted, right after the twelfth falling edge.
- R6: After reset and whenever the block is idle, chip select is high, the serial clock is low, MOSI is low, busy is low and done is low.
- R7: A start request while busy is high is ignored. The running conversion, its control word and its result are unaffected.
- R8: done is a one-cycle pulse. result changes only together with done and holds its value until the next done.
- R9: result_sx sign-extends result from bit 11 when the finished conversion was requested in bipolar mode, so codes 0x800 and above are negative. Otherwise it zero-extends result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| chan | input | 3 | Input channel to convert |
| range_sel | input | 1 | Range-select bit for the control word |
| bipolar | input | 1 | Bipolar-mode bit for the control word |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Last conversion code |
| result_sx | output | 16 | Extended copy of result, sign- or zero-extended |

## Verification
Each result follows the accepted start edge by a fixed number of cycles. With H the half-period and W the wait, the k-th control bit sits on MOSI from cycle 2kH and the clock rises at cycle (2k+1)H. The read frame opens at cycle 16H+W. done, result and the released chip select all appear at cycle 40H+W. The bench model counts cycles from the same accepted edge and derives every expected pin value from that count. It samples on the falling system clock edge, half a cycle after the registers have settled. A converter model on the pins captures the control word on rising serial edges, drives the code on falling edges, and measures every serial clock phase against the 200 ns minimum.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int HALF_DIV = 10,
  parameter int WAIT_CYC = 750,
  parameter int RES_W    = 12,
  parameter int SX_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       chan,
  input  logic             range_sel,
  input  logic             bipolar,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [SX_W-1:0]  result_sx
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int WW = $clog2(WAIT_CYC + 1);
  localparam int BW = $clog2(((RES_W > 8) ? RES_W : 8) + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_GAP, S_RD} st_t;

  st_t             st;
  logic [DW-1:0]   div;
  logic [WW-1:0]   wcnt;
  logic [BW-1:0]   nbit;
  logic [7:0]      sh;
  logic [RES_W-1:0] rx;
  logic            bip_q, res_bip;

  wire half_end = (div == DW'(HALF_DIV - 1));
  wire last_bit = (st == S_WR) ? (nbit == BW'(7)) : (nbit == BW'(RES_W - 1));

  assign mosi = sh[7];
  assign busy = (st != S_IDLE);
  assign result_sx = res_bip ? {{(SX_W-RES_W){result[RES_W-1]}}, result}
                             : {{(SX_W-RES_W){1'b0}}, result};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      sh      <= '0;
      div     <= '0;
      wcnt    <= '0;
      nbit    <= '0;
      rx      <= '0;
      result  <= '0;
      bip_q   <= 1'b0;
      res_bip <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_WR;
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          sh    <= {1'b1, chan, range_sel, bipolar, 2'b00};
          bip_q <= bipolar;
          div   <= '0;
          nbit  <= '0;
        end
        S_GAP: begin
          if (wcnt == WW'(WAIT_CYC - 1)) begin
            st   <= S_RD;
            wcnt <= '0;
            div  <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: begin
          if (!half_end) begin
            div <= div + 1'b1;
          end else begin
            div <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              if (st == S_RD) rx <= {rx[RES_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (st == S_WR) sh <= {sh[6:0], 1'b0};
              if (!last_bit) begin
                nbit <= nbit + 1'b1;
              end else begin
                nbit <= '0;
                if (st == S_WR) begin
                  st   <= S_GAP;
                  wcnt <= '0;
                end else begin
                  st      <= S_IDLE;
                  cs_n    <= 1'b1;
                  done    <= 1'b1;
                  result  <= rx;
                  res_bip <= bip_q;
                end
              end
            end
          end
        end
      endcase
    end
  end
endmodule

module adc_conv_seq_chk #(parameter int RES_W = 12) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic [RES_W-1:0] result
);
  p_idle_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n && !sclk);
  p_cs_gates_sclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_held_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> mosi);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && !sclk && !busy);
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .result(result)
);

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
  localparam int H  = 10;
  localparam int W  = 750;
  localparam int T0 = 16*H + W;
  localparam int TE = T0 + 24*H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan = '0;
  logic range_sel = 1'b0, bipolar = 1'b0;
  logic cs_n, sclk, mosi, busy, done;
  logic miso = 1'b0;
  logic [11:0] result;
  logic [15:0] result_sx;

  int vectors = 0, errors = 0;

  always #10 clk = ~clk;

  adc_conv_seq i_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
    .range_sel(range_sel), .bipolar(bipolar), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso), .busy(busy), .done(done),
    .result(result), .result_sx(result_sx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter model on the pins
  logic [11:0] slv_code = '0;
  logic [7:0]  slv_byte = '0;
  int          slv_rise = 0;
  always @(negedge cs_n) slv_rise = 0;
  always @(posedge sclk) begin
    if (slv_rise < 8) slv_byte = {slv_byte[6:0], mosi};
    slv_rise++;
  end
  always @(negedge sclk)
    if (slv_rise >= 8 && slv_rise < 20) miso = slv_code[11 - (slv_rise - 8)];
    else miso = 1'b0;

  // reference model: cycles since the accepted start edge
  bit          active = 0, done_m = 0, bip_res = 0;
  int          t = 0;
  logic [7:0]  ctrl_m = '0;
  logic [11:0] code_m = '0, res_m = '0;
  always @(posedge clk) begin
    done_m = 0;
    if (!rst_n) begin
      active = 0; res_m = '0; bip_res = 0;
    end else if (active) begin
      t++;
      if (t == TE) begin
        active = 0; done_m = 1; res_m = code_m; bip_res = ctrl_m[2];
      end
    end else if (start) begin
      active = 1; t = 0;
      ctrl_m = {1'b1, chan, range_sel, bipolar, 2'b00};
      code_m = slv_code;
    end
  end

  int  run = 0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    logic e_cs, e_sclk, e_mosi;
    logic [15:0] e_sx;
    if (!rst_n) begin
      check("R6 reset cs_n", cs_n, 1);
      check("R6 reset sclk", sclk, 0);
      check("R6 reset busy", busy, 0);
      check("R6 reset done", done, 0);
    end else begin
      e_cs = 1; e_sclk = 0; e_mosi = 0;
      if (active) begin
        e_cs = 0;
        if (t < 16*H) begin
          e_sclk = (t % (2*H)) >= H;
          e_mosi = ctrl_m[7 - t/(2*H)];
        end else if (t >= T0) begin
          e_sclk = ((t - T0) % (2*H)) >= H;
        end
      end
      e_sx = bip_res ? {{4{res_m[11]}}, res_m} : {4'h0, res_m};
      check("R5/R6 cs_n", cs_n, e_cs);
      check("R3/R4 sclk", sclk, e_sclk);
      check("R1/R2 mosi", mosi, e_mosi);
      check("R7 busy", busy, active);
      check("R8 done", done, done_m);
      check("R5/R8 result", result, res_m);
      check("R9 result_sx", result_sx, e_sx);
      if (sclk !== sclk_prev) begin
        check("R3 min phase 200ns", (run >= H) ? 1 : 0, 1);
        run = 1;
      end else run++;
      sclk_prev = sclk;
    end
  end

  task automatic conv(input logic [2:0] c, input logic r, input logic b,
                      input logic [11:0] code, input int poke);
    slv_code = code;
    @(negedge clk);
    chan = c; range_sel = r; bipolar = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chan = ~c; range_sel = ~r; bipolar = ~b;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1;   // R7: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check("R1 control word", slv_byte, {1'b1, c, r, b, 2'b00});
    check("R5 read result", result, code);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    conv(3'd0, 1'b0, 1'b0, 12'h000, 0);
    conv(3'd7, 1'b1, 1'b1, 12'hFFF, 0);
    conv(3'd5, 1'b0, 1'b1, 12'h800, 40);
    conv(3'd2, 1'b1, 1'b0, 12'h7FF, 400);
    conv(3'd3, 1'b0, 1'b1, 12'hA5C, 1000);
    conv(3'd6, 1'b1, 1'b0, 12'h9C3, 0);
    conv(3'd1, 1'b0, 1'b1, 12'h123, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule